// File: doc/BRIEF.md
# Quarter-Wave Sine Oscillator

This block is a numerically controlled sine source. On every clock it adds a tuning word to a wide phase register. It then uses the upper phase bits to look up one unsigned sample of a sine wave, which is meant for a parallel resistor-ladder DAC. The tuning word may change on any cycle. The output frequency is the tuning word times the clock rate, divided by two to the power of the phase width. With the default 32-bit phase and a 12 MHz clock, one step of the word is worth about 0.0028 Hz. A word of 93664 therefore gives roughly 261.6 Hz.

Only one quarter of a period is stored, as a small read-only table that is computed when the design is elaborated. The two most significant phase bits pick the quadrant. The lower bit of the pair reverses the walk through the table, so the falling quarters reuse the rising one. The upper bit reflects the table value below mid-scale. The table samples the quarter at half-step offsets, so the reversed quarters meet the forward ones without repeating the peak or the zero crossing.

Top module: `dds_sine_top`

## Requirements
- R1: The phase register adds `freq_word` once per rising clock edge and wraps modulo 2^32. A word of zero leaves the phase, and so the output, unchanged.
- R2: The sample presented after clock edge k is computed from the phase that the register held after edge k-2. A new word applied before edge k first moves the phase at edge k.
- R3: The quarter table entry i (i = 0..63) equals round(511 * sin(pi/2 * (i + 0.5) / 64)). Entry 0 is 6 and entry 63 is 511.
- R4: The table position is a sample index n made of phase bits [31:24]. Bits [31:30] are the quadrant and bits [29:24] are the offset. In quadrants 00 and 10 the offset addresses the table directly. In quadrants 01 and 11 the bitwise inverse of the offset is used. Therefore index n and index 127-n give the same sample.
- R5: In quadrants 00 and 01 the sample is 511 plus the table entry. In quadrants 10 and 11 it is 511 minus the table entry. Index 0 gives 517, indices 63 and 64 give 1022, index 128 gives 505, and indices 191 and 192 give 0.
- R6: Reset is synchronous and active high. While it is held, the phase is cleared and the output is 511. The first sample after release (phase 0) is 517.
- R7: The output never exceeds 1022. The samples for index n and index n+128 always add up to 1022.
- R8: When the word divides 2^32 exactly, the output repeats every 2^32/word clocks. That is 256 clocks for 2^24 and 64 clocks for 2^26.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | 32 | Phase increment added every clock |
| sample_o | output | 10 | Unsigned sine sample, mid-scale 511 |

## Verification
The quadrant seams are the hardest cases to reach from the ports. These are the steps 63 to 64, 127 to 128, 191 to 192 and the wrap back to 0. At those points the address direction or the reflection flips, and an ordinary audio word passes over them in a single step among millions of phase values. The stimulus uses a word of 2^24, so the sample index advances by exactly one per clock and every one of the 256 positions appears in order. Captured samples are then compared against mirrored and half-period partners. A 2^26 word, the C4 word, a word switched mid-run and a held zero word are also run against a per-clock model, so the two-edge latency is exercised across word changes.

// File: rtl/dds_pkg.sv
package dds_pkg;
  // default geometry of the oscillator
  localparam int unsigned PHASE_W_D = 32;
  localparam int unsigned INDEX_W_D = 8;
  localparam int unsigned AMP_W_D   = 10;

  // bit roles inside the two-bit quadrant code
  localparam int unsigned Q_MIRROR_BIT = 0;
  localparam int unsigned Q_NEGATE_BIT = 1;

  typedef logic [1:0] quadrant_t;

  localparam real HALF_PI = 1.5707963267948966;
endpackage

// File: rtl/phase_accum.sv
module phase_accum
  import dds_pkg::*;
#(
  parameter int unsigned PHASE_W = PHASE_W_D,
  parameter int unsigned INDEX_W = INDEX_W_D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] step,
  output logic [INDEX_W-1:0] index
);
  logic [PHASE_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + step;
  end

  assign index = acc_q[PHASE_W-1 -: INDEX_W];

  // R1
  hold_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> $stable(index));
endmodule

// File: rtl/quarter_rom.sv
module quarter_rom
  import dds_pkg::*;
#(
  parameter int unsigned ADDR_W = INDEX_W_D - 2,
  parameter int unsigned MAG_W  = AMP_W_D - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [MAG_W-1:0]  data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam real PEAK = real'((1 << MAG_W) - 1);

  logic [MAG_W-1:0] table_mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      table_mem[i] = MAG_W'($rtoi(PEAK * $sin(HALF_PI * (real'(i) + 0.5) / real'(DEPTH)) + 0.5));
    end
  end

  // registered read, runs during reset too so the pipeline is primed
  always_ff @(posedge clk) begin
    data <= table_mem[addr];
  end

  // R3
  rom_steady_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(addr) |=> $stable(data));
endmodule

// File: rtl/wave_fold.sv
module wave_fold
  import dds_pkg::*;
#(
  parameter int unsigned INDEX_W = INDEX_W_D,
  parameter int unsigned AMP_W   = AMP_W_D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] index,
  output logic [INDEX_W-3:0] rom_addr,
  input  logic [AMP_W-2:0]   rom_data,
  output logic [AMP_W-1:0]   sample
);
  localparam int unsigned ADDR_W = INDEX_W - 2;
  localparam logic [AMP_W-1:0] MID = AMP_W'((1 << (AMP_W - 1)) - 1);

  quadrant_t           quad_now;
  quadrant_t           quad_q;
  logic [ADDR_W-1:0]   offset;

  assign quad_now = index[INDEX_W-1 -: 2];
  assign offset   = index[ADDR_W-1:0];
  assign rom_addr = quad_now[Q_MIRROR_BIT] ? ~offset : offset;

  // quadrant travels alongside the table read
  always_ff @(posedge clk) begin
    if (rst) quad_q <= '0;
    else     quad_q <= quad_now;
  end

  always_ff @(posedge clk) begin
    if (rst)                       sample <= MID;
    else if (quad_q[Q_NEGATE_BIT]) sample <= MID - AMP_W'(rom_data);
    else                           sample <= MID + AMP_W'(rom_data);
  end

  // R5
  upper_half_chk: assert property (@(posedge clk) disable iff (rst)
    !quad_q[Q_NEGATE_BIT] |=> (sample >= MID));

  // R7
  no_full_code_chk: assert property (@(posedge clk) disable iff (rst)
    sample != '1);

  // R6
  reset_mid_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sample == MID));
endmodule

// File: rtl/dds_sine_top.sv
module dds_sine_top
  import dds_pkg::*;
#(
  parameter int unsigned PHASE_W = PHASE_W_D,
  parameter int unsigned INDEX_W = INDEX_W_D,
  parameter int unsigned AMP_W   = AMP_W_D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] freq_word,
  output logic [AMP_W-1:0]   sample_o
);
  localparam int unsigned ADDR_W = INDEX_W - 2;
  localparam int unsigned MAG_W  = AMP_W - 1;

  logic [INDEX_W-1:0] index;
  logic [ADDR_W-1:0]  rom_addr;
  logic [MAG_W-1:0]   rom_data;

  phase_accum #(.PHASE_W(PHASE_W), .INDEX_W(INDEX_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .step  (freq_word),
    .index (index)
  );

  quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (rom_addr),
    .data (rom_data)
  );

  wave_fold #(.INDEX_W(INDEX_W), .AMP_W(AMP_W)) u_fold (
    .clk      (clk),
    .rst      (rst),
    .index    (index),
    .rom_addr (rom_addr),
    .rom_data (rom_data),
    .sample   (sample_o)
  );

  // R4
  mirror_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (index[INDEX_W-2] && (index[ADDR_W-1:0] == '0)) |-> (rom_addr == '1));
endmodule

// File: tb/sim_dds_sine_top.sv
`timescale 1ns/1ps
module sim_dds_sine_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] freq_word = '0;
  logic [9:0]  sample_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  dds_sine_top u0 (.clk(clk), .rst(rst), .freq_word(freq_word), .sample_o(sample_o));

  // reference: sample value for an 8-bit position n
  function automatic int ref_sample(int n);
    int q = n / 64;
    int off = n % 64;
    int t;
    if (q % 2 == 1) off = 63 - off;
    t = $rtoi(511.0 * $sin(1.5707963267948966 * (real'(off) + 0.5) / 64.0) + 0.5);
    return (q < 2) ? 511 + t : 511 - t;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // cycle model: phase history two edges deep
  logic [31:0] m_ph = '0;
  logic [31:0] m_prev = '0;
  int exp_out = 511;

  always @(posedge clk) begin
    if (rst) exp_out = 511;
    else     exp_out = ref_sample(int'(m_prev[31:24]));
    m_prev = m_ph;
    m_ph = rst ? 32'd0 : m_ph + freq_word;
  end

  always @(negedge clk) begin
    if (model_on) chk("R2 model", int'(sample_o), exp_out);
  end

  int smp [0:599];

  task automatic capture(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp[i] = int'(sample_o);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R6: reset holds mid-scale
    freq_word = 32'h0100_0000;
    repeat (3) @(negedge clk);
    chk("R6 reset value", int'(sample_o), 511);
    rst = 1'b0;
    model_on = 1;
    capture(600);
    // smp[i] holds position max(i-1,0)
    chk("R6 first sample", smp[0], 517);
    chk("R5 index0", smp[1], 517);
    chk("R5 index63", smp[64], 1022);
    chk("R5 index64", smp[65], 1022);
    chk("R5 index128", smp[129], 505);
    chk("R5 index191", smp[192], 0);
    chk("R5 index192", smp[193], 0);
    chk("R3 entry63 peak", smp[64] - 511, 511);
    chk("R3 entry0", smp[1] - 511, 6);
    for (int k = 0; k < 64; k++) chk("R4 mirror", smp[1 + k], smp[1 + 127 - k]);
    for (int k = 0; k < 128; k++) chk("R7 antisym", smp[1 + k] + smp[1 + k + 128], 1022);
    for (int k = 1; k < 300; k++) chk("R8 period256", smp[k + 256], smp[k]);
    for (int k = 0; k < 600; k++) if (smp[k] > 1022) chk("R7 range", smp[k], 1022);

    // R8: word 2^26 repeats every 64
    freq_word = 32'h0400_0000;
    repeat (4) @(negedge clk);
    capture(200);
    for (int k = 0; k < 130; k++) chk("R8 period64", smp[k + 64], smp[k]);

    // R1/R2: audio word and odd words with mid-run change
    freq_word = 32'd93664;
    repeat (200) @(negedge clk);
    freq_word = 32'h1234_5679;
    repeat (150) @(negedge clk);
    freq_word = 32'hFFFF_FF01;
    repeat (50) @(negedge clk);

    // R1: zero word freezes output
    freq_word = 32'd0;
    repeat (3) @(negedge clk);
    capture(20);
    for (int k = 1; k < 20; k++) chk("R1 zero word", smp[k], smp[0]);

    // R6: reset mid-run
    freq_word = 32'h0300_0000;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 mid-run reset", int'(sample_o), 511);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 restart", int'(sample_o), 517);
    repeat (40) @(negedge clk);

    model_on = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule